// File: doc/BRIEF.md
# Timing Reference Selector

This block decides which of five candidate timing references drives the downstream clock-recovery loop, or whether that loop should coast on stored history (holdover) or run open (freerun). Per-reference qualification flags and programmable priorities arrive from the monitoring logic. The block reports the chosen index and an operating state.

Three selection modes exist. In automatic mode an elector ranks the qualified references by priority, and a revertive setting decides whether a better reference takes over from a working one. In manual mode a code forces a reference, holdover or freerun. In hard-wired mode a synchronised pin flips between two preset references. The elector keeps tracking its inputs in every mode, so a return to automatic mode picks up its current decision at once. Any change of the reported selection raises a one-cycle pulse.

Top module: `ref_selector`

## Requirements
- R1: While reset is applied and until the first update after its release, `op_state` is freerun (0), `sel_idx` is 0 and `sel_change` is 0. State codes: 0 freerun, 1 holdover, 2 locked.
- R2: In automatic mode with no working selection, the elector locks to the qualified reference with the highest nonzero priority. Ties go to the lower index. The result appears one clock edge after the inputs.
- R3: A reference whose 4-bit priority field (bits `4*i+3:4*i` of `ref_prio` for reference i) is zero is never elected, even if qualified.
- R4: With `revert_en` high, a qualified reference with strictly higher priority than the current qualified selection replaces it on the next edge.
- R5: With `revert_en` low, the current selection is kept while it stays qualified with nonzero priority, even if a higher-priority reference qualifies.
- R6: When the current selection loses qualification, the elector moves on the next edge to the best remaining qualified reference. This happens with either revertive setting.
- R7: In automatic mode, when no reference is eligible, the state is holdover if `hold_ok` is high and freerun otherwise. `sel_idx` is 0 whenever the state is not locked.
- R8: In manual mode (`sel_mode` = 1), `man_code` values 0 to 4 lock to that reference whatever its qualification. Code 5 forces holdover. Codes 6 and 7 force freerun.
- R9: In hard-wired mode (`sel_mode` = 2), the synchronised `hw_switch` picks `hw_pick_a` when low and `hw_pick_b` when high. A pin change shows on the outputs at the third clock edge. A pick of 5 or more gives freerun.
- R10: In manual and hard-wired modes, changes to qualification or priority do not alter the outputs.
- R11: `sel_change` is high for exactly the cycles in which `sel_idx` or `op_state` differs from its value in the previous cycle.
- R12: `sel_mode` = 3 behaves as automatic mode (0).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ref_qual | input | 5 | Qualified flag per reference |
| ref_prio | input | 20 | Packed 4-bit priority per reference, larger is better, 0 disables |
| revert_en | input | 1 | Revertive election enable |
| sel_mode | input | 2 | 0 automatic, 1 manual, 2 hard-wired, 3 automatic |
| man_code | input | 3 | Manual choice: reference index, 5 holdover, 6/7 freerun |
| hw_pick_a | input | 3 | Reference used in hard-wired mode with the pin low |
| hw_pick_b | input | 3 | Reference used in hard-wired mode with the pin high |
| hw_switch | input | 1 | Asynchronous fast-switch pin |
| hold_ok | input | 1 | Holdover history is available |
| sel_idx | output | 3 | Selected reference index, 0 when not locked |
| op_state | output | 2 | 0 freerun, 1 holdover, 2 locked |
| sel_change | output | 1 | One-cycle pulse when the selection or state changes |

## Verification
Results driven by qualification, priority, mode, manual code and history appear one clock edge after the inputs settle. The change pulse rises on that same edge. The fast-switch pin crosses two synchroniser stages, so its effect is due on the third edge. The bench checks that the old value still holds after two edges and that the new value appears after the third. Every input is driven 1 ns after a rising edge, and every output is sampled 1 ns after the edge that should have updated it. This way each check falls in exactly the cycle its latency predicts.

// File: rtl/ref_sel_pkg.sv
package ref_sel_pkg;

  typedef enum logic [1:0] {
    OP_FREERUN  = 2'd0,
    OP_HOLDOVER = 2'd1,
    OP_LOCKED   = 2'd2
  } op_state_e;

  typedef enum logic [1:0] {
    SM_AUTO      = 2'd0,
    SM_MANUAL    = 2'd1,
    SM_HARDWIRED = 2'd2,
    SM_AUTO_ALT  = 2'd3
  } sel_mode_e;

endpackage

// File: rtl/ref_sel_sync.sv
module ref_sel_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], d};
    end
  end

  assign q = chain_q[STAGES-1];

endmodule

// File: rtl/ref_sel_best.sv
module ref_sel_best #(
  parameter int N  = 5,
  parameter int PW = 4,
  parameter int IW = 3
) (
  input  logic [N-1:0]    ref_qual,
  input  logic [N*PW-1:0] ref_prio,
  output logic            best_any,
  output logic [IW-1:0]   best_idx,
  output logic [PW-1:0]   best_prio
);

  logic [N-1:0] elig;

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_elig
      assign elig[g] = ref_qual[g] && (ref_prio[g*PW +: PW] != '0);
    end
  endgenerate

  // Ascending scan with a strict compare: equal priorities keep the lower index.
  always_comb begin
    best_idx  = '0;
    best_prio = '0;
    for (int i = 0; i < N; i++) begin
      if (elig[i] && (ref_prio[i*PW +: PW] > best_prio)) begin
        best_idx  = IW'(i);
        best_prio = ref_prio[i*PW +: PW];
      end
    end
  end

  assign best_any = |elig;

endmodule

// File: rtl/ref_sel_elector.sv
module ref_sel_elector
  import ref_sel_pkg::*;
#(
  parameter int N  = 5,
  parameter int PW = 4,
  parameter int IW = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N-1:0]    ref_qual,
  input  logic [N*PW-1:0] ref_prio,
  input  logic            revert_en,
  input  logic            hold_ok,
  input  logic            best_any,
  input  logic [IW-1:0]   best_idx,
  input  logic [PW-1:0]   best_prio,
  output op_state_e       nxt_state,
  output logic [IW-1:0]   nxt_idx
);

  op_state_e       st_q;
  logic [IW-1:0]   idx_q;
  logic            cur_qual;
  logic [PW-1:0]   cur_prio;
  logic            cur_ok;
  logic            upd_en;

  always_comb begin
    cur_qual = 1'b0;
    cur_prio = '0;
    for (int i = 0; i < N; i++) begin
      if (idx_q == IW'(i)) begin
        cur_qual = ref_qual[i];
        cur_prio = ref_prio[i*PW +: PW];
      end
    end
  end

  assign cur_ok = (st_q == OP_LOCKED) && cur_qual && (cur_prio != '0);

  always_comb begin
    nxt_state = st_q;
    nxt_idx   = idx_q;
    if (cur_ok) begin
      if (revert_en && best_any && (best_prio > cur_prio)) begin
        nxt_state = OP_LOCKED;
        nxt_idx   = best_idx;
      end
    end else if (best_any) begin
      nxt_state = OP_LOCKED;
      nxt_idx   = best_idx;
    end else if (hold_ok) begin
      nxt_state = OP_HOLDOVER;
      nxt_idx   = '0;
    end else begin
      nxt_state = OP_FREERUN;
      nxt_idx   = '0;
    end
  end

  assign upd_en = (nxt_state != st_q) || (nxt_idx != idx_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= OP_FREERUN;
      idx_q <= '0;
    end else if (upd_en) begin
      st_q  <= nxt_state;
      idx_q <= nxt_idx;
    end
  end

endmodule

// File: rtl/ref_selector.sv
module ref_selector
  import ref_sel_pkg::*;
#(
  parameter int N_REFS      = 5,
  parameter int PRIO_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [N_REFS-1:0]          ref_qual,
  input  logic [N_REFS*PRIO_W-1:0]   ref_prio,
  input  logic                       revert_en,
  input  logic [1:0]                 sel_mode,
  input  logic [$clog2(N_REFS+2)-1:0] man_code,
  input  logic [$clog2(N_REFS)-1:0]  hw_pick_a,
  input  logic [$clog2(N_REFS)-1:0]  hw_pick_b,
  input  logic                       hw_switch,
  input  logic                       hold_ok,
  output logic [$clog2(N_REFS)-1:0]  sel_idx,
  output logic [1:0]                 op_state,
  output logic                       sel_change
);

  localparam int IDX_W  = $clog2(N_REFS);
  localparam int CODE_W = $clog2(N_REFS + 2);

  logic             rst_ok;
  logic             sw_s;
  logic             best_any;
  logic [IDX_W-1:0] best_idx;
  logic [PRIO_W-1:0] best_prio;
  op_state_e        el_state;
  logic [IDX_W-1:0] el_idx;
  logic [IDX_W-1:0] hw_pick;

  op_state_e        out_st_d, out_st_q;
  logic [IDX_W-1:0] out_idx_d, out_idx_q;
  logic             chg_d, chg_q;

  ref_sel_sync #(.STAGES(2)) u_rst_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (1'b1),
    .q     (rst_ok)
  );

  ref_sel_sync #(.STAGES(SYNC_STAGES)) u_pin_sync (
    .clk   (clk),
    .rst_n (rst_ok),
    .d     (hw_switch),
    .q     (sw_s)
  );

  ref_sel_best #(.N(N_REFS), .PW(PRIO_W), .IW(IDX_W)) u_best (
    .ref_qual  (ref_qual),
    .ref_prio  (ref_prio),
    .best_any  (best_any),
    .best_idx  (best_idx),
    .best_prio (best_prio)
  );

  ref_sel_elector #(.N(N_REFS), .PW(PRIO_W), .IW(IDX_W)) u_elector (
    .clk       (clk),
    .rst_n     (rst_ok),
    .ref_qual  (ref_qual),
    .ref_prio  (ref_prio),
    .revert_en (revert_en),
    .hold_ok   (hold_ok),
    .best_any  (best_any),
    .best_idx  (best_idx),
    .best_prio (best_prio),
    .nxt_state (el_state),
    .nxt_idx   (el_idx)
  );

  assign hw_pick = sw_s ? hw_pick_b : hw_pick_a;

  always_comb begin
    out_st_d  = OP_FREERUN;
    out_idx_d = '0;
    unique case (sel_mode_e'(sel_mode))
      SM_MANUAL: begin
        if (man_code < CODE_W'(N_REFS)) begin
          out_st_d  = OP_LOCKED;
          out_idx_d = man_code[IDX_W-1:0];
        end else if (man_code == CODE_W'(N_REFS)) begin
          out_st_d  = OP_HOLDOVER;
        end
      end
      SM_HARDWIRED: begin
        if ({1'b0, hw_pick} < (IDX_W+1)'(N_REFS)) begin
          out_st_d  = OP_LOCKED;
          out_idx_d = hw_pick;
        end
      end
      default: begin
        out_st_d  = el_state;
        out_idx_d = el_idx;
      end
    endcase
  end

  assign chg_d = (out_st_d != out_st_q) || (out_idx_d != out_idx_q);

  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) begin
      out_st_q  <= OP_FREERUN;
      out_idx_q <= '0;
    end else if (chg_d) begin
      out_st_q  <= out_st_d;
      out_idx_q <= out_idx_d;
    end
  end

  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) begin
      chg_q <= 1'b0;
    end else begin
      chg_q <= chg_d;
    end
  end

  assign sel_idx    = out_idx_q;
  assign op_state   = out_st_q;
  assign sel_change = chg_q;

endmodule

// File: rtl/ref_selector_chk.sv
module ref_selector_chk #(
  parameter int N  = 5,
  parameter int PW = 4,
  parameter int IW = 3,
  parameter int CW = 3
) (
  input logic          clk,
  input logic          rst_ok,
  input logic [N-1:0]  ref_qual,
  input logic [N*PW-1:0] ref_prio,
  input logic [1:0]    sel_mode,
  input logic [CW-1:0] man_code,
  input logic          hold_ok,
  input logic [IW-1:0] sel_idx,
  input logic [1:0]    op_state,
  input logic          sel_change
);

  logic [N-1:0]    qual_q;
  logic [N*PW-1:0] prio_q;
  logic [1:0]      mode_q;
  logic [CW-1:0]   man_q;
  logic            hold_q;
  logic            seen_q;
  logic            sel_elig;
  logic            auto_q;

  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) begin
      qual_q <= '0;
      prio_q <= '0;
      mode_q <= '0;
      man_q  <= '0;
      hold_q <= 1'b0;
      seen_q <= 1'b0;
    end else begin
      qual_q <= ref_qual;
      prio_q <= ref_prio;
      mode_q <= sel_mode;
      man_q  <= man_code;
      hold_q <= hold_ok;
      seen_q <= 1'b1;
    end
  end

  always_comb begin
    sel_elig = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (sel_idx == IW'(i)) begin
        sel_elig = qual_q[i] && (prio_q[i*PW +: PW] != '0);
      end
    end
  end

  assign auto_q = (mode_q == 2'd0) || (mode_q == 2'd3);

  assert_pulse_has_cause_R11: assert property (@(posedge clk) disable iff (!rst_ok)
    sel_change |-> ((sel_idx != $past(sel_idx)) || (op_state != $past(op_state))));

  assert_move_has_pulse_R11: assert property (@(posedge clk) disable iff (!rst_ok)
    ((sel_idx != $past(sel_idx)) || (op_state != $past(op_state))) |-> sel_change);

  assert_idle_index_zero_R7: assert property (@(posedge clk) disable iff (!rst_ok)
    (op_state != 2'd2) |-> (sel_idx == '0));

  assert_auto_pick_eligible_R3: assert property (@(posedge clk) disable iff (!rst_ok)
    (seen_q && auto_q && (op_state == 2'd2)) |-> sel_elig);

  assert_auto_fallback_R7: assert property (@(posedge clk) disable iff (!rst_ok)
    (seen_q && auto_q && (qual_q == '0)) |-> (op_state == (hold_q ? 2'd1 : 2'd0)));

  assert_manual_force_R8: assert property (@(posedge clk) disable iff (!rst_ok)
    (seen_q && (mode_q == 2'd1) && (man_q < CW'(N))) |->
      ((op_state == 2'd2) && (sel_idx == man_q[IW-1:0])));

endmodule

bind ref_selector ref_selector_chk #(
  .N  (N_REFS),
  .PW (PRIO_W),
  .IW ($clog2(N_REFS)),
  .CW ($clog2(N_REFS + 2))
) u_chk (
  .clk        (clk),
  .rst_ok     (rst_ok),
  .ref_qual   (ref_qual),
  .ref_prio   (ref_prio),
  .sel_mode   (sel_mode),
  .man_code   (man_code),
  .hold_ok    (hold_ok),
  .sel_idx    (sel_idx),
  .op_state   (op_state),
  .sel_change (sel_change)
);

// File: tb/sim_ref_selector.sv
`timescale 1ns/1ps
module sim_ref_selector;

  logic        clk;
  logic        rst_n;
  logic [4:0]  ref_qual;
  logic [19:0] ref_prio;
  logic        revert_en;
  logic [1:0]  sel_mode;
  logic [2:0]  man_code;
  logic [2:0]  hw_pick_a;
  logic [2:0]  hw_pick_b;
  logic        hw_switch;
  logic        hold_ok;
  logic [2:0]  sel_idx;
  logic [1:0]  op_state;
  logic        sel_change;

  int checks = 0;
  int fails  = 0;

  localparam int FREE = 0;
  localparam int HOLD = 1;
  localparam int LOCK = 2;

  ref_selector u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .ref_qual   (ref_qual),
    .ref_prio   (ref_prio),
    .revert_en  (revert_en),
    .sel_mode   (sel_mode),
    .man_code   (man_code),
    .hw_pick_a  (hw_pick_a),
    .hw_pick_b  (hw_pick_b),
    .hw_switch  (hw_switch),
    .hold_ok    (hold_ok),
    .sel_idx    (sel_idx),
    .op_state   (op_state),
    .sel_change (sel_change)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic expect_out(string req, int st, int idx, int chg);
    chk(req, "op_state", int'(op_state), st);
    chk(req, "sel_idx", int'(sel_idx), idx);
    chk(req, "sel_change", int'(sel_change), chg);
  endtask

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic set_prio(int r, int v);
    ref_prio[r*4 +: 4] = 4'(v);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    step(3);
    expect_out("R1", FREE, 0, 0);
    rst_n = 1'b1;
    step(4);
    expect_out("R1", FREE, 0, 0);
  endtask

  task automatic t_auto_best();
    set_prio(0, 3); set_prio(1, 7); set_prio(2, 7); set_prio(3, 2); set_prio(4, 0);
    ref_qual = 5'b11111;
    step(1);
    expect_out("R2", LOCK, 1, 1);
    step(1);
    expect_out("R11", LOCK, 1, 0);
  endtask

  task automatic t_zero_prio();
    ref_qual = 5'b11000;
    step(1);
    expect_out("R3", LOCK, 3, 1);
    ref_qual = 5'b10000;
    hold_ok  = 1'b1;
    step(1);
    expect_out("R3", HOLD, 0, 1);
  endtask

  task automatic t_revert();
    set_prio(0, 5);
    ref_qual = 5'b01000;
    step(1);
    expect_out("R2", LOCK, 3, 1);
    revert_en = 1'b1;
    ref_qual  = 5'b01001;
    step(1);
    expect_out("R4", LOCK, 0, 1);
  endtask

  task automatic t_nonrevert();
    revert_en = 1'b0;
    set_prio(2, 9);
    ref_qual = 5'b00101;
    step(1);
    expect_out("R5", LOCK, 0, 0);
    ref_qual = 5'b00110;
    step(1);
    expect_out("R6", LOCK, 2, 1);
  endtask

  task automatic t_fallback();
    ref_qual = 5'b00000;
    hold_ok  = 1'b1;
    step(1);
    expect_out("R7", HOLD, 0, 1);
    hold_ok = 1'b0;
    step(1);
    expect_out("R7", FREE, 0, 1);
  endtask

  task automatic t_manual();
    sel_mode = 2'd1;
    man_code = 3'd4;
    step(1);
    expect_out("R8", LOCK, 4, 1);
    man_code = 3'd5;
    step(1);
    expect_out("R8", HOLD, 0, 1);
    man_code = 3'd6;
    step(1);
    expect_out("R8", FREE, 0, 1);
    man_code = 3'd7;
    step(1);
    expect_out("R8", FREE, 0, 0);
    man_code = 3'd2;
    step(1);
    expect_out("R8", LOCK, 2, 1);
    ref_qual = 5'b00011;
    set_prio(1, 8);
    step(2);
    expect_out("R10", LOCK, 2, 0);
  endtask

  task automatic t_hardwired();
    hw_pick_a = 3'd1;
    hw_pick_b = 3'd3;
    hw_switch = 1'b0;
    sel_mode  = 2'd2;
    step(1);
    expect_out("R9", LOCK, 1, 1);
    hw_switch = 1'b1;
    step(2);
    expect_out("R9", LOCK, 1, 0);
    step(1);
    expect_out("R9", LOCK, 3, 1);
    hw_pick_b = 3'd6;
    step(1);
    expect_out("R9", FREE, 0, 1);
    ref_qual = 5'b00010;
    set_prio(3, 15);
    step(2);
    expect_out("R10", FREE, 0, 0);
  endtask

  task automatic t_spare_mode();
    sel_mode = 2'd3;
    step(1);
    expect_out("R12", LOCK, 1, 1);
    sel_mode = 2'd0;
    step(1);
    expect_out("R12", LOCK, 1, 0);
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n     = 1'b0;
    ref_qual  = '0;
    ref_prio  = '0;
    revert_en = 1'b0;
    sel_mode  = 2'd0;
    man_code  = '0;
    hw_pick_a = '0;
    hw_pick_b = '0;
    hw_switch = 1'b0;
    hold_ok   = 1'b0;
    t_reset();
    t_auto_best();
    t_zero_prio();
    t_revert();
    t_nonrevert();
    t_fallback();
    t_manual();
    t_hardwired();
    t_spare_mode();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule